// File: doc/BRIEF.md
# Rotated Framebuffer Scanout Address Generator

This block produces the pixel read addresses that keep a small TFT panel refreshed from a framebuffer in memory. A frame consists of a fixed number of scan lines, blanking lines first and visible lines after them. Every line holds a fixed number of 16-bit pixel reads. When the last address of a frame has been taken, the sequence starts again at the first line, so refresh continues without any outside help. The block issues addresses only; the memory and the pixel data path sit elsewhere.

Two addressing modes are available. In portrait mode the addresses walk the buffer linearly, 2 bytes per pixel, without a break at line boundaries. In landscape mode the buffer holds a rotated image, and each scan line walks one buffer column, with a stride of one full buffer row. The visible lines take the columns from the last column to the first. All blanking lines read the column that starts at the base address. The consumer takes addresses through a ready/valid handshake. Flags mark the first pixel of each line and the first pixel of each frame. The base address and the mode are captured when the first beat of a frame is accepted and are held for the rest of that frame.

Top module: `scanout_addr_gen`

## Requirements
- R1: `valid_o` is 0 while `rst_n` is low. The first beat after reset is line 0 pixel 0, with `frame_start_o`=1, `line_start_o`=1 and `addr_o` equal to the live `base_i`.
- R2: Each line has PIX_PER_LINE beats, and each frame has BLANK_LINES+VIS_LINES lines. `line_start_o` is 1 on pixel 0 of every line and only there. `frame_start_o` is 1 on pixel 0 of line 0 and only there.
- R3: Portrait mode (`mode_i`=0). Beat n of a frame, where n = line*PIX_PER_LINE + pixel, has address base + n*2.
- R4: Landscape mode (`mode_i`=1), on a blanking line (line < BLANK_LINES). The address is base + pixel*VIS_LINES*2.
- R5: Landscape mode, on a visible line L (BLANK_LINES <= L < TOTAL, where TOTAL = BLANK_LINES+VIS_LINES). The address is base + (TOTAL-1-L)*2 + pixel*VIS_LINES*2.
- R6: After the last beat of the last line is accepted, the next beat is the first beat of a new frame.
- R7: While `ready_i` is 0, the current beat is held. Its address and flags stay unchanged, except that the address of a frame-start beat follows `base_i`. No address is lost or repeated.
- R8: `mode_i` and `base_i` are sampled only when a frame-start beat is accepted. Changing them during a frame has no effect on the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | ADDR_W | Framebuffer base byte address |
| mode_i | input | 1 | 0 = portrait linear walk, 1 = landscape column walk |
| ready_i | input | 1 | Consumer takes the current address |
| valid_o | output | 1 | Address is valid |
| addr_o | output | ADDR_W | Pixel read byte address |
| line_start_o | output | 1 | Current beat is pixel 0 of a line |
| frame_start_o | output | 1 | Current beat is pixel 0 of line 0 |

## Verification
The assertions assume that `base_i` is stable whenever it matters, which is at the moment a frame-start beat is accepted. They also assume that a stall on a non-start beat holds the address register. The stimulus changes `mode_i` and `base_i` only in two places. It sets them at the start of a frame, and it flips them once in the middle of each frame to test that they are ignored there. The address check for a frame-start beat always uses the value currently on `base_i`. Ready follows three patterns: always high, pseudo-random, and long low bursts. These patterns are crossed with both modes on a reduced geometry, and every beat of every frame is checked.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic {
        MODE_PORTRAIT  = 1'b0,
        MODE_LANDSCAPE = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/scan_pos_counter.sv
module scan_pos_counter #(
    parameter int PIX_PER_LINE = 240,
    parameter int TOTAL_LINES  = 329,
    localparam int PX_W = (PIX_PER_LINE > 1) ? $clog2(PIX_PER_LINE) : 1,
    localparam int LN_W = (TOTAL_LINES > 1) ? $clog2(TOTAL_LINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    output logic [PX_W-1:0] px_o,
    output logic [LN_W-1:0] line_o,
    output logic            last_px_o,
    output logic            last_line_o
);
    localparam logic [PX_W-1:0] PX_LAST = PX_W'(PIX_PER_LINE - 1);
    localparam logic [LN_W-1:0] LN_LAST = LN_W'(TOTAL_LINES - 1);

    typedef struct packed {
        logic [PX_W-1:0] px;
        logic [LN_W-1:0] ln;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (adv_i) begin
            if (pos_q.px == PX_LAST) begin
                pos_d.px = '0;
                pos_d.ln = (pos_q.ln == LN_LAST) ? '0 : pos_q.ln + 1'b1;
            end else begin
                pos_d.px = pos_q.px + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign px_o        = pos_q.px;
    assign line_o      = pos_q.ln;
    assign last_px_o   = (pos_q.px == PX_LAST);
    assign last_line_o = (pos_q.ln == LN_LAST);

    // R2: position never leaves the scan geometry
    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.px <= PX_LAST) && (pos_q.ln <= LN_LAST));

    // R2: a line ends only after its last pixel
    assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && (pos_q.px != PX_LAST)) |=> $stable(pos_q.ln));
endmodule

// File: rtl/scan_addr_step.sv
module scan_addr_step #(
    parameter int ADDR_W        = 32,
    parameter int VIS_LINES     = 320,
    parameter int BLANK_LINES   = 9,
    parameter int BYTES_PER_PIX = 2,
    parameter int LN_W          = 9
) (
    input  scan_pkg::scan_mode_e mode_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    cur_i,
    input  logic                 last_px_i,
    input  logic                 last_line_i,
    input  logic [LN_W-1:0]      line_i,
    output logic [ADDR_W-1:0]    next_o
);
    localparam int TOTAL_LINES = VIS_LINES + BLANK_LINES;
    localparam logic [ADDR_W-1:0] PIX_STEP = ADDR_W'(BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] COL_STEP = ADDR_W'(VIS_LINES * BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(TOTAL_LINES - 1);
    localparam logic [LN_W:0]     BLANK_N  = (LN_W+1)'(BLANK_LINES);

    logic [LN_W:0]     nl;
    logic [ADDR_W-1:0] col_off;

    always_comb begin
        nl      = {1'b0, line_i} + 1'b1;
        col_off = (LAST_IDX - ADDR_W'(nl)) * PIX_STEP;
        if (!last_px_i) begin
            next_o = cur_i + ((mode_i == scan_pkg::MODE_LANDSCAPE) ? COL_STEP : PIX_STEP);
        end else if (last_line_i) begin
            next_o = base_i;
        end else if (mode_i == scan_pkg::MODE_PORTRAIT) begin
            next_o = cur_i + PIX_STEP;
        end else if (nl < BLANK_N) begin
            next_o = base_i;
        end else begin
            next_o = base_i + col_off;
        end
    end
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
    parameter int ADDR_W        = 32,
    parameter int PIX_PER_LINE  = 240,
    parameter int VIS_LINES     = 320,
    parameter int BLANK_LINES   = 9,
    parameter int BYTES_PER_PIX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              mode_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              line_start_o,
    output logic              frame_start_o
);
    import scan_pkg::*;

    localparam int TOTAL_LINES = VIS_LINES + BLANK_LINES;
    localparam int PX_W = (PIX_PER_LINE > 1) ? $clog2(PIX_PER_LINE) : 1;
    localparam int LN_W = (TOTAL_LINES > 1) ? $clog2(TOTAL_LINES) : 1;
    localparam logic [ADDR_W-1:0] PIX_STEP = ADDR_W'(BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] COL_STEP = ADDR_W'(VIS_LINES * BYTES_PER_PIX);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        scan_mode_e        mode;
        logic              valid;
    } st_t;

    st_t st_d, st_q;

    logic [PX_W-1:0]   px;
    logic [LN_W-1:0]   line;
    logic              last_px, last_line;
    logic              hs, fs;
    scan_mode_e        mode_eff;
    logic [ADDR_W-1:0] base_eff, cur, nxt;

    assign hs = st_q.valid && ready_i;
    assign fs = st_q.valid && (px == '0) && (line == '0);

    scan_pos_counter #(
        .PIX_PER_LINE (PIX_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES)
    ) pos_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (hs),
        .px_o        (px),
        .line_o      (line),
        .last_px_o   (last_px),
        .last_line_o (last_line)
    );

    always_comb begin
        mode_eff = fs ? scan_mode_e'(mode_i) : st_q.mode;
        base_eff = fs ? base_i : st_q.base;
        cur      = fs ? base_i : st_q.addr;
    end

    scan_addr_step #(
        .ADDR_W        (ADDR_W),
        .VIS_LINES     (VIS_LINES),
        .BLANK_LINES   (BLANK_LINES),
        .BYTES_PER_PIX (BYTES_PER_PIX),
        .LN_W          (LN_W)
    ) step_i (
        .mode_i      (mode_eff),
        .base_i      (base_eff),
        .cur_i       (cur),
        .last_px_i   (last_px),
        .last_line_i (last_line),
        .line_i      (line),
        .next_o      (nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b1;
        if (hs) begin
            st_d.addr = nxt;
            st_d.base = base_eff;
            st_d.mode = mode_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.base  <= '0;
            st_q.mode  <= MODE_PORTRAIT;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o       = st_q.valid;
    assign addr_o        = cur;
    assign line_start_o  = st_q.valid && (px == '0);
    assign frame_start_o = fs;

    // R1: once valid, the address stream never pauses on its own
    assert_valid_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R7: a stalled non-start beat keeps address and flags
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !frame_start_o)
        |=> ($stable(addr_o) && $stable(line_start_o) && !frame_start_o));

    // R6: accepting the final beat of a frame starts a new frame
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && last_px && last_line) |=> frame_start_o);

    // R8: the frame's mode is frozen between frame starts
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !frame_start_o) |=> $stable(st_q.mode));

    // R3: portrait pixels inside a line are BYTES_PER_PIX apart
    assert_portrait_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !fs && !last_px && st_q.mode == MODE_PORTRAIT)
        |=> (addr_o == $past(addr_o) + PIX_STEP));

    // R4: landscape pixels inside a line are one buffer row apart
    assert_landscape_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !fs && !last_px && st_q.mode == MODE_LANDSCAPE)
        |=> (addr_o == $past(addr_o) + COL_STEP));
endmodule

// File: tb/scanout_addr_gen_tb.sv
module scanout_addr_gen_tb_top;
    localparam int AW    = 32;
    localparam int PIX   = 6;
    localparam int VIS   = 10;
    localparam int BLANK = 3;
    localparam int BPP   = 2;
    localparam int TOT   = VIS + BLANK;
    localparam int FRAME_BEATS = PIX * TOT;
    localparam int MID_BEAT = 40;
    localparam int NFRAMES  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic          mode_i = 1'b0;
    logic          ready_i = 1'b0;
    logic          valid_o;
    logic [AW-1:0] addr_o;
    logic          line_start_o;
    logic          frame_start_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scanout_addr_gen #(
        .ADDR_W(AW), .PIX_PER_LINE(PIX), .VIS_LINES(VIS),
        .BLANK_LINES(BLANK), .BYTES_PER_PIX(BPP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .mode_i(mode_i),
        .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o),
        .line_start_o(line_start_o), .frame_start_o(frame_start_o)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input bit m, input logic [AW-1:0] b,
                                               input int ln, input int px);
        if (!m) return b + AW'((ln * PIX + px) * BPP);
        if (ln < BLANK) return b + AW'(px * VIS * BPP);
        return b + AW'((TOT - 1 - ln) * BPP + px * VIS * BPP);
    endfunction

    initial begin
        int ln = 0;
        int px = 0;
        int frame = 0;
        bit mm = 0;
        logic [AW-1:0] mb = '0;
        logic [15:0] lfsr = 16'hACE1;
        bit prev_stall = 0;
        logic [AW-1:0] prev_addr = '0;
        bit want;
        int bidx;
        string tag;

        repeat (3) @(negedge clk);
        check("R1 valid_o during reset", AW'(valid_o), AW'(0));
        rst_n = 1'b1;

        while (frame < NFRAMES) begin
            @(negedge clk);
            bidx = ln * PIX + px;
            want = ((frame / 3) % 2) == 1;
            if (bidx == 0) begin
                mode_i = want;
                base_i = AW'(32'h0001_0000 + frame * 32'h100);
            end else if (bidx == MID_BEAT) begin
                mode_i = ~want;
                base_i = 32'hDEAD_0000;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (frame % 3)
                0: ready_i = 1'b1;
                1: ready_i = lfsr[0];
                default: ready_i = (lfsr[2:0] == 3'b000);
            endcase
            #1;
            if (bidx == 0 && frame == 0) tag = "R1";
            else if (bidx == 0) tag = "R6";
            else if (prev_stall) tag = "R7";
            else if (bidx > MID_BEAT) tag = "R8";
            else if (!mm) tag = "R3";
            else if (ln < BLANK) tag = "R4";
            else tag = "R5";

            check({tag, " valid_o"}, AW'(valid_o), AW'(1));
            check("R2 line_start_o", AW'(line_start_o), AW'(px == 0));
            check("R2 frame_start_o", AW'(frame_start_o), AW'(bidx == 0));
            if (bidx == 0) check({tag, " addr frame start"}, addr_o, base_i);
            else check({tag, " addr"}, addr_o, exp_addr(mm, mb, ln, px));
            if (prev_stall && bidx != 0) check("R7 addr held over stall", addr_o, prev_addr);
            if (bidx != 0 && mm == 1 && ln < BLANK) check("R4 blanking column", addr_o, mb + AW'(px * VIS * BPP));
            if (bidx != 0 && mm == 1 && ln == BLANK && px == 0)
                check("R5 first visible line start", addr_o, mb + AW'((VIS - 1) * BPP));

            prev_addr = addr_o;
            prev_stall = !ready_i;
            if (ready_i) begin
                if (bidx == 0) begin
                    mm = mode_i;
                    mb = base_i;
                end
                if (px == PIX - 1) begin
                    px = 0;
                    if (ln == TOT - 1) begin
                        ln = 0;
                        frame++;
                    end else ln++;
                end else px++;
            end
        end
        if (FRAME_BEATS <= 0) check("R2 geometry", 0, 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule